// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block takes a three-wire stereo audio link (bit clock, frame clock, serial data) and turns it into parallel left and right sample words. The two link clocks are not used as clocks. They and the data line are brought into a faster system clock domain through synchronizers, and each detected rising edge of the bit clock becomes one sampling slot.

A format select chooses right-justified 16-bit, right-justified 18-bit, left-justified 16-bit or I2S framing. A ratio select chooses 64 or 32 bit clocks per frame. Slots that hold no sample bits are discarded. Both words come out sign-extended to 18 bits, together with a single-cycle strobe once per stereo frame. A frame whose half-frame length does not match the selected ratio is dropped, and an error strobe is raised.

Top module: `aud_ser_rx`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` and `err_o` are low and both sample outputs are zero until the first frame is reported.
- R2: The bit clock, frame clock and data pass through a two-flop synchronizer. The data bit is taken on each detected rising edge of the bit clock, and the first bit of each word is its MSB.
- R3: With `fmt_i`=0 (right-justified, 16 bits) or `fmt_i`=1 (right-justified, 18 bits) at 64 slots per frame, the LSB of each word is the last slot of its half-frame. The leading slots have no effect on the outputs.
- R4: With `fmt_i`=2 (left-justified, 16 bits), the MSB is slot 0, which is the first bit-clock rise after the frame clock changes. The trailing slots have no effect.
- R5: With `fmt_i`=3 (I2S), the MSB is slot 1. The word is 18 bits at 64 slots per frame and 16 bits at 32. At 32 slots the LSB falls in slot 0 of the following half-frame.
- R6: With `ratio32_i`=1, each half-frame has 16 slots and every format carries 16-bit words. With `ratio32_i`=0, each half-frame has 32 slots.
- R7: `valid_o` is high for exactly one cycle per stereo frame, at the start of the next left half-frame, and presents both words of the completed frame. `left_o` and `right_o` change only in a cycle where `valid_o` is high.
- R8: 16-bit words are sign-extended to 18 bits, so bits 17 and 16 equal bit 15.
- R9: The left channel is the half-frame where the frame clock is low in I2S mode and high in the justified modes. Parameters set these levels.
- R10: If a half-frame length differs from the selected ratio, `err_o` pulses for one cycle and that stereo frame produces no `valid_o`. The first stereo frame after reset is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Link bit clock (asynchronous) |
| fclk_i | input | 1 | Link frame (left/right) clock (asynchronous) |
| sdat_i | input | 1 | Link serial data, MSB first |
| fmt_i | input | 2 | Framing: 0 RJ16, 1 RJ18, 2 LJ16, 3 I2S |
| ratio32_i | input | 1 | 1: 32 bit clocks per frame, 0: 64 |
| left_o | output | 18 | Left sample, sign-extended |
| right_o | output | 18 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe with a new stereo frame |
| err_o | output | 1 | One-cycle strobe on a half-frame length error |

## Verification
Some properties are checked on every cycle. The valid and error strobes each last a single cycle, a length error never coincides with a valid strobe, and the sample outputs hold steady except when valid is high. Only the bench scenarios show the rest: where each format places its word, that don't-care slots are discarded, the 32-slot I2S word whose LSB spills into the next half, sign extension, and channel polarity. The bench drives every format and ratio pairing with extreme and patterned words, and noise in every unused slot. It also sends over-long and short half-frames to show that exactly the affected frame is dropped.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;
  typedef enum logic [1:0] {
    FMT_RJ16 = 2'd0,
    FMT_RJ18 = 2'd1,
    FMT_LJ16 = 2'd2,
    FMT_I2S  = 2'd3
  } aud_fmt_e;
endpackage

// File: rtl/aud_ser_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit inputs.
module aud_ser_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/aud_ser_framer.sv
// Tracks the slot position inside each half-frame and checks half-frame length.
module aud_ser_framer #(
  parameter int HALF_LONG  = 32,
  parameter int HALF_SHORT = 16,
  parameter int SLOT_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              fclk_i,
  input  logic              short_i,
  output logic              edge_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              len_ok_o,
  output logic              locked_o,
  output logic              lock_now_o
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic              fclk_q, fclk_d;
  logic              locked_q, locked_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [SLOT_W-1:0] half_m1;

  assign half_m1 = short_i ? SLOT_W'(HALF_SHORT - 1) : SLOT_W'(HALF_LONG - 1);
  assign edge_o  = tick_i && (fclk_i != fclk_q);

  always_comb begin
    fclk_d   = fclk_i;
    locked_d = locked_q;
    slot_d   = slot_q;
    if (edge_o) begin
      slot_d   = '0;
      locked_d = 1'b1;
    end else if (slot_q != SLOT_MAX) begin
      slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_q   <= 1'b0;
      locked_q <= 1'b0;
      slot_q   <= '0;
    end else if (tick_i) begin
      fclk_q   <= fclk_d;
      locked_q <= locked_d;
      slot_q   <= slot_d;
    end
  end

  assign slot_o     = slot_d;
  assign len_ok_o   = (slot_q == half_m1);
  assign locked_o   = locked_q;
  assign lock_now_o = locked_d;
endmodule

// File: rtl/aud_ser_shift.sv
// Serial-to-parallel capture of one word, 16 or 18 bits, MSB first.
module aud_ser_shift #(
  parameter int OUT_W   = 18,
  parameter int SHORT_W = 16,
  parameter int CNT_W   = $clog2(OUT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             bit_i,
  input  logic             long_i,
  input  logic             ch_i,
  output logic             done_o,
  output logic             done_ch_o,
  output logic [OUT_W-1:0] word_o
);
  logic [OUT_W-2:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ch_q, ch_d;
  logic [OUT_W-1:0] sh_cat;

  assign sh_cat = {sh_q, bit_i};

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    ch_d  = ch_q;
    if (start_i) begin
      sh_d  = {{(OUT_W-2){1'b0}}, bit_i};
      cnt_d = long_i ? CNT_W'(OUT_W - 1) : CNT_W'(SHORT_W - 1);
      ch_d  = ch_i;
    end else if (cnt_q != '0) begin
      sh_d  = sh_cat[OUT_W-2:0];
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      ch_q  <= 1'b0;
    end else if (tick_i) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      ch_q  <= ch_d;
    end
  end

  assign done_o    = tick_i && !start_i && (cnt_q == CNT_W'(1));
  assign done_ch_o = ch_q;
  assign word_o    = long_i ? sh_cat
                            : {{(OUT_W-SHORT_W){sh_cat[SHORT_W-1]}}, sh_cat[SHORT_W-1:0]};
endmodule

// File: rtl/aud_ser_rx.sv
// Multi-format stereo audio serial receiver (top).
module aud_ser_rx
  import aud_ser_pkg::*;
#(
  parameter int   OUT_W         = 18,
  parameter int   SHORT_W       = 16,
  parameter int   HALF_LONG     = 32,
  parameter int   HALF_SHORT    = 16,
  parameter logic I2S_LEFT_LVL  = 1'b0,
  parameter logic JUST_LEFT_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_i,
  input  logic             fclk_i,
  input  logic             sdat_i,
  input  logic [1:0]       fmt_i,
  input  logic             ratio32_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o,
  output logic             err_o
);
  localparam int SLOT_W = $clog2(HALF_LONG) + 1;

  aud_fmt_e fmt;
  assign fmt = aud_fmt_e'(fmt_i);

  // synchronizers and bit-clock rise detection
  logic [2:0] sync_w;
  logic       bclk_d_q, tick;
  aud_ser_sync #(.N(3), .STAGES(2)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sdat_i, fclk_i, bclk_i}),
    .sync_o  (sync_w)
  );
  assign tick = sync_w[0] & ~bclk_d_q;

  // framing configuration
  logic              wlong, is_left, left_lvl;
  logic [SLOT_W-1:0] half_s, wlen_s, start_slot;

  assign wlong    = !ratio32_i && (fmt == FMT_RJ18 || fmt == FMT_I2S);
  assign half_s   = ratio32_i ? SLOT_W'(HALF_SHORT) : SLOT_W'(HALF_LONG);
  assign wlen_s   = wlong ? SLOT_W'(OUT_W) : SLOT_W'(SHORT_W);
  assign left_lvl = (fmt == FMT_I2S) ? I2S_LEFT_LVL : JUST_LEFT_LVL;
  assign is_left  = (sync_w[1] == left_lvl);

  always_comb begin
    case (fmt)
      FMT_LJ16: start_slot = '0;
      FMT_I2S:  start_slot = SLOT_W'(1);
      default:  start_slot = half_s - wlen_s;
    endcase
  end

  // slot tracking
  logic              fr_edge, fr_len_ok, fr_locked, fr_lock_now;
  logic [SLOT_W-1:0] fr_slot;
  aud_ser_framer #(.HALF_LONG(HALF_LONG), .HALF_SHORT(HALF_SHORT), .SLOT_W(SLOT_W)) framer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .fclk_i     (sync_w[1]),
    .short_i    (ratio32_i),
    .edge_o     (fr_edge),
    .slot_o     (fr_slot),
    .len_ok_o   (fr_len_ok),
    .locked_o   (fr_locked),
    .lock_now_o (fr_lock_now)
  );

  // word capture
  logic             cap_start, sh_done, sh_ch;
  logic [OUT_W-1:0] sh_word;
  assign cap_start = tick && fr_lock_now && (fr_slot == start_slot);

  aud_ser_shift #(.OUT_W(OUT_W), .SHORT_W(SHORT_W)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .start_i   (cap_start),
    .bit_i     (sync_w[2]),
    .long_i    (wlong),
    .ch_i      (is_left),
    .done_o    (sh_done),
    .done_ch_o (sh_ch),
    .word_o    (sh_word)
  );

  // frame assembly and reporting
  logic [OUT_W-1:0] lcap_q, lcap_d, rcap_q, rcap_d, left_d, right_d;
  logic             ok_q, ok_d, ldone_q, ldone_d, rdone_q, rdone_d;
  logic             valid_d, err_d;
  logic             l_now, r_now, into_left, bad_len, fire;

  always_comb begin
    l_now     = sh_done & sh_ch;
    r_now     = sh_done & ~sh_ch;
    lcap_d    = l_now ? sh_word : lcap_q;
    rcap_d    = r_now ? sh_word : rcap_q;
    into_left = fr_edge & is_left;
    bad_len   = fr_edge & fr_locked & ~fr_len_ok;
    fire      = into_left & ok_q & ~bad_len & (ldone_q | l_now) & (rdone_q | r_now);
    if (into_left)    ok_d = fr_locked;
    else if (bad_len) ok_d = 1'b0;
    else              ok_d = ok_q;
    ldone_d = l_now | (ldone_q & ~into_left);
    rdone_d = into_left ? 1'b0 : (rdone_q | r_now);
    left_d  = fire ? lcap_d : left_o;
    right_d = fire ? rcap_d : right_o;
    valid_d = fire;
    err_d   = bad_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d_q <= 1'b0;
      lcap_q   <= '0;
      rcap_q   <= '0;
      ok_q     <= 1'b0;
      ldone_q  <= 1'b0;
      rdone_q  <= 1'b0;
      left_o   <= '0;
      right_o  <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      bclk_d_q <= sync_w[0];
      valid_o  <= valid_d;
      err_o    <= err_d;
      if (tick) begin
        lcap_q  <= lcap_d;
        rcap_q  <= rcap_d;
        ok_q    <= ok_d;
        ldone_q <= ldone_d;
        rdone_q <= rdone_d;
        left_o  <= left_d;
        right_o <= right_d;
      end
    end
  end
endmodule

// File: rtl/aud_ser_rx_chk.sv
// Port-level protocol checks, bound into the receiver.
module aud_ser_rx_chk #(
  parameter int OUT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OUT_W-1:0] left_o,
  input logic [OUT_W-1:0] right_o,
  input logic             valid_o,
  input logic             err_o
);
  // R7: the frame strobe never lasts two cycles
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R10: the length error strobe never lasts two cycles
  a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R10: a length error never comes with a reported frame
  a_r10_err_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);

  // R7: samples move only together with the strobe
  a_r7_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left_o) |-> valid_o);

  a_r7_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_o) |-> valid_o);
endmodule

bind aud_ser_rx aud_ser_rx_chk #(.OUT_W(OUT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .left_o  (left_o),
  .right_o (right_o),
  .valid_o (valid_o),
  .err_o   (err_o)
);

// File: tb/aud_ser_rx_tb_top.sv
module aud_ser_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, fclk = 1'b0, sdat = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        r32 = 1'b0;
  logic [17:0] lo, ro;
  logic        vo, eo;

  always #2 clk = ~clk;

  aud_ser_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk), .sdat_i(sdat),
    .fmt_i(fmt), .ratio32_i(r32), .left_o(lo), .right_o(ro),
    .valid_o(vo), .err_o(eo)
  );

  int    checks = 0, fails = 0;
  int    got = 0, errs = 0, nxt = 1, bad_fr = -1;
  int    cyc = 0;
  string req = "R3";
  logic [17:0] lw [0:7];
  logic [17:0] rw [0:7];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog R7: got %0d cycles, expected fewer", cyc);
      summary();
      $finish;
    end
  end

  function automatic int wl();
    return (!r32 && (fmt == 2'd1 || fmt == 2'd3)) ? 18 : 16;
  endfunction
  function automatic int half();
    return r32 ? 16 : 32;
  endfunction
  function automatic int st();
    if (fmt <= 2'd1) return half() - wl();
    if (fmt == 2'd2) return 0;
    return 1;
  endfunction
  function automatic logic lvl_left();
    return (fmt == 2'd3) ? 1'b0 : 1'b1;
  endfunction
  function automatic logic [17:0] sx(logic [17:0] v);
    if (wl() == 18) return v;
    return {{2{v[15]}}, v[15:0]};
  endfunction
  function automatic logic [17:0] base(int k);
    case (k)
      0: return 18'h2D3A7;
      1: return (18'h1 << (wl() - 1)) - 18'h1;   // max positive
      2: return 18'h1 << (wl() - 1);             // most negative
      3: return 18'h0;
      4: return 18'h3FFFF;
      5: return 18'h15555;
      6: return 18'h0C9E1;
      default: return 18'h31F0B;
    endcase
  endfunction
  function automatic logic [17:0] msk(logic [17:0] v);
    return (wl() == 18) ? v : {2'b00, v[15:0]};
  endfunction

  function automatic logic bitval(int fr, int h, int s);
    logic [17:0] cur, prv;
    int w, a;
    w = wl(); a = st();
    cur = (h == 0) ? lw[fr] : rw[fr];
    prv = (h == 1) ? lw[fr] : ((fr > 0) ? rw[fr-1] : 18'h0);
    if (s >= a && s < a + w) return cur[w-1-(s-a)];
    if (a + w > half() && s < a + w - half()) return prv[w-1-(half()-a+s)];
    return ((s + fr) % 3) == 0;   // noise in unused slots
  endfunction

  // compare every reported frame against the stream that was sent
  always @(negedge clk) begin
    if (eo) errs++;
    if (vo) begin
      got++;
      if (nxt == bad_fr) nxt++;
      if (nxt < 8) begin
        checks += 2;
        if (lo !== sx(lw[nxt])) begin
          fails++;
          $display("FAIL %s R2 R8 R9 frame %0d left: got %h expected %h", req, nxt, lo, sx(lw[nxt]));
        end
        if (ro !== sx(rw[nxt])) begin
          fails++;
          $display("FAIL %s R2 R8 R9 frame %0d right: got %h expected %h", req, nxt, ro, sx(rw[nxt]));
        end
      end
      nxt++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_cfg(logic [1:0] f, logic r, string tag, int bad, int delta);
    int nexp;
    fmt = f; r32 = r; req = tag; bad_fr = bad;
    rst_n = 1'b0; bclk = 1'b0; sdat = 1'b0; fclk = ~lvl_left();
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 reset valid/err", int'(vo) + int'(eo), 0);
    chk("R1 reset samples", int'(lo != 18'h0) + int'(ro != 18'h0), 0);
    for (int i = 0; i < 8; i++) begin
      lw[i] = msk(base(i));
      rw[i] = msk(base((i + 3) % 8));
    end
    nxt = 1; got = 0; errs = 0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int fr = 0; fr < 7; fr++) begin
      for (int h = 0; h < 2; h++) begin
        int n;
        n = half() + ((fr == bad && h == 0) ? delta : 0);
        for (int s = 0; s < n; s++) begin
          fclk = (h == 0) ? lvl_left() : ~lvl_left();
          sdat = bitval(fr, h, s);
          #12 bclk = 1'b1;
          #12 bclk = 1'b0;
        end
      end
    end
    #100;
    nexp = 5 - ((bad >= 1 && bad <= 5) ? 1 : 0);
    chk({tag, " R7 R10 frame count"}, got, nexp);
    chk({tag, " R10 error strobes"}, errs, (bad >= 0) ? 1 : 0);
  endtask

  initial begin
    run_cfg(2'd0, 1'b0, "R3", -1, 0);   // right-justified 16
    run_cfg(2'd1, 1'b0, "R3", -1, 0);   // right-justified 18
    run_cfg(2'd2, 1'b0, "R4", -1, 0);   // left-justified 16
    run_cfg(2'd3, 1'b0, "R5", -1, 0);   // I2S 18 at 64 slots
    run_cfg(2'd3, 1'b1, "R5", -1, 0);   // I2S 16 at 32 slots, LSB spills
    run_cfg(2'd0, 1'b1, "R6", -1, 0);   // right-justified at 32 slots
    run_cfg(2'd2, 1'b1, "R6", -1, 0);   // left-justified at 32 slots
    run_cfg(2'd0, 1'b0, "R10", 2, 1);   // long half-frame
    run_cfg(2'd2, 1'b0, "R10", 3, -1);  // short half-frame
    summary();
    $finish;
  end
endmodule